// File: doc/BRIEF.md
# Smart Card Session Sequencer

This block sits between a host controller and one contact smart card slot. It turns a small set of host control levels into an ordered power-up and power-down of the card contacts. The host asks for a session by pulling `cmd_vcc_n` low. The block then switches the card supply on, checks that the supply has settled, starts the card clock, opens the data-line receiver and finally lets the card reset line follow the host's reset level. When the host lets `cmd_vcc_n` go high again, or when trouble appears during a session, the contacts are released in the opposite order.

Trouble can be an over-current flag, a supply-fault flag, a supply that never reports valid, or a card pulled out of the slot. Any of these drives the active-low `irq_n` to the host, and the line stays low until the host ends the session. Outside a session, `irq_n` simply shows whether a card is inserted. After reset, and again after leaving power-down, the block waits through a fixed hold-off (`HOLD_CYC` cycles, ten milliseconds at the intended clock rate) before it will act on a request. A power-down request is only obeyed while no session is requested.

All pins are plain control levels. Nothing carries a data stream, so there is no valid/ready handshake and no back-pressure. Analog supply, oscillator and pad behaviour appear only as enables and flags.

Top module: `card_session_seq`

## Requirements
- R1: After reset is released, no supply enable is given until the hold-off has run. With a request and a card already present, `vcc_en` rises on clock edge `HOLD_CYC+1` after reset release.
- R2: Leaving power-down (`pwr_dn_req` sampled low) restarts the hold-off. `vcc_en` rises `HOLD_CYC+1` edges after that sampling edge when a session is requested.
- R3: A session starts only while `card_present` is 1. With the card absent, a low `cmd_vcc_n` leaves every card output at 0.
- R4: Activation order: `vcc_en` rises on the edge that samples the request (edge s). `clk_en` rises at s+`STEP_CYC`. `io_rx_en` rises at s+2·`STEP_CYC`. From edge s+3·`STEP_CYC`+1 on, `card_rst` copies `rst_in` with one cycle of delay. `io_rx_en` and `card_rst` are never raised at any other point.
- R5: On the edge that ends the supply step (s+`STEP_CYC`), `vcc_ok` must be 1. If it is not, or if `vcc_ok` drops at any later point of the session, this counts as a fault.
- R6: During a session, any bit of `sup_flt` or `ocp_flt` at 1, or `card_present` at 0, sampled on edge T, drives `irq_n` low from T and starts deactivation at T.
- R7: Deactivation starting at edge T drops `card_rst` at T, `clk_en` at T+`STEP_CYC`, `io_rx_en` at T+2·`STEP_CYC` and `vcc_en` at T+3·`STEP_CYC`. An output that had not been raised stays at 0.
- R8: If the host raises `cmd_vcc_n` during a session, the same deactivation runs with `irq_n` kept high, and the block goes back to idle.
- R9: `pwr_dn_req` puts the block into power-down only while `cmd_vcc_n` is 1 and no session is running. During a session it has no effect. In power-down, all card outputs stay at 0.
- R10: Outside a session, `irq_n` equals `card_present`. A reported fault is cleared once the host has raised `cmd_vcc_n` and the block has returned to idle.
- R11: If a fault and a host release are sampled on the same edge, the fault wins: `irq_n` goes low, and deactivation follows the R7 timing.
- R12: If `pwr_dn_req` rises on the same edge as `cmd_vcc_n` falls while idle with a card present, the session starts and power-down is not entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vcc_n | input | 1 | Host session request, active low |
| rst_in | input | 1 | Host reset level, passed on to the card once the session is up |
| pwr_dn_req | input | 1 | Host power-down request, active high |
| card_present | input | 1 | 1 while a card sits in the slot |
| vcc_ok | input | 1 | Card supply has reached its valid level |
| sup_flt | input | N_SUP | Supply fault flags, active high |
| ocp_flt | input | N_OCP | Over-current flags, active high |
| vcc_en | output | 1 | Card supply enable |
| clk_en | output | 1 | Card clock enable |
| io_rx_en | output | 1 | Data-line reception enable |
| card_rst | output | 1 | Card reset contact level |
| irq_n | output | 1 | Active-low status/interrupt line to the host |

## Verification
Two functions can land on the same edge: an ending requested by the host, and a fault-driven ending. The bench provokes this by raising `cmd_vcc_n` and pulling `card_present` low on the same falling clock edge while the session is fully up. It then expects `irq_n` to drop right after the next rising edge, with the release steps at the same offsets as a clean ending. The same kind of collision is tested when idle: a power-down request and a session request arrive together, and the supply must come on at once. A sweep then injects each kind of fault, or a host release, at every cycle of the activation and the first active cycles. For each injection, the bench works out the edge of every rise and fall from the step length.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

  typedef enum logic [3:0] {
    SQ_HOLD     = 4'd0,
    SQ_IDLE     = 4'd1,
    SQ_PDOWN    = 4'd2,
    SQ_UP_VCC   = 4'd3,
    SQ_UP_CLK   = 4'd4,
    SQ_UP_IO    = 4'd5,
    SQ_LIVE     = 4'd6,
    SQ_DN_RST   = 4'd7,
    SQ_DN_CLK   = 4'd8,
    SQ_DN_IO    = 4'd9,
    SQ_WAIT_REL = 4'd10
  } seq_state_e;

  function automatic logic is_session(input seq_state_e s);
    return (s == SQ_UP_VCC) || (s == SQ_UP_CLK) || (s == SQ_UP_IO) || (s == SQ_LIVE);
  endfunction

  function automatic logic is_timed(input seq_state_e s);
    return (s == SQ_UP_VCC) || (s == SQ_UP_CLK) || (s == SQ_UP_IO) ||
           (s == SQ_DN_RST) || (s == SQ_DN_CLK) || (s == SQ_DN_IO);
  endfunction

  function automatic logic is_outside(input seq_state_e s);
    return (s == SQ_HOLD) || (s == SQ_IDLE) || (s == SQ_PDOWN);
  endfunction

endpackage

// File: rtl/css_cycle_timer.sv
module css_cycle_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic done
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || restart) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R7
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/css_fault_merge.sv
module css_fault_merge #(
  parameter int unsigned N_SUP = 2,
  parameter int unsigned N_OCP = 2
) (
  input  logic             card_present,
  input  logic [N_SUP-1:0] sup_flt,
  input  logic [N_OCP-1:0] ocp_flt,
  output logic             flt_any
);
  logic [N_SUP:0] sup_acc;
  logic [N_OCP:0] ocp_acc;

  assign sup_acc[0] = 1'b0;
  assign ocp_acc[0] = 1'b0;

  for (genvar g = 0; g < N_SUP; g++) begin : g_sup
    assign sup_acc[g+1] = sup_acc[g] | sup_flt[g];
  end

  for (genvar g = 0; g < N_OCP; g++) begin : g_ocp
    assign ocp_acc[g+1] = ocp_acc[g] | ocp_flt[g];
  end

  assign flt_any = sup_acc[N_SUP] | ocp_acc[N_OCP] | ~card_present;

endmodule

// File: rtl/css_fsm.sv
module css_fsm
  import card_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_vcc_n,
  input  logic rst_in,
  input  logic pwr_dn_req,
  input  logic card_present,
  input  logic vcc_ok,
  input  logic flt_any,
  input  logic hold_done,
  input  logic step_done,
  output logic hold_run,
  output logic step_run,
  output logic tmr_restart,
  output logic vcc_en,
  output logic clk_en,
  output logic io_rx_en,
  output logic card_rst,
  output logic irq_n
);
  seq_state_e state_q, nxt;
  logic vcc_q, clk_q, io_q, rst_q, flt_q;
  logic in_sess, vcc_bad, flt_now, rel_now, pd_ok;

  assign in_sess = is_session(state_q);
  assign vcc_bad = !vcc_ok &&
                   ((state_q == SQ_UP_CLK) || (state_q == SQ_UP_IO) || (state_q == SQ_LIVE) ||
                    ((state_q == SQ_UP_VCC) && step_done));
  assign flt_now = in_sess && (flt_any || vcc_bad);
  assign rel_now = in_sess && cmd_vcc_n;
  assign pd_ok   = pwr_dn_req && cmd_vcc_n;

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      SQ_HOLD: begin
        if (pd_ok)          nxt = SQ_PDOWN;
        else if (hold_done) nxt = SQ_IDLE;
      end
      SQ_IDLE: begin
        if (!cmd_vcc_n && card_present) nxt = SQ_UP_VCC;
        else if (pd_ok)                 nxt = SQ_PDOWN;
      end
      SQ_PDOWN: begin
        if (!pwr_dn_req) nxt = SQ_HOLD;
      end
      SQ_UP_VCC: begin
        if (flt_now || rel_now) nxt = SQ_DN_RST;
        else if (step_done)     nxt = SQ_UP_CLK;
      end
      SQ_UP_CLK: begin
        if (flt_now || rel_now) nxt = SQ_DN_RST;
        else if (step_done)     nxt = SQ_UP_IO;
      end
      SQ_UP_IO: begin
        if (flt_now || rel_now) nxt = SQ_DN_RST;
        else if (step_done)     nxt = SQ_LIVE;
      end
      SQ_LIVE: begin
        if (flt_now || rel_now) nxt = SQ_DN_RST;
      end
      SQ_DN_RST: begin
        if (step_done) nxt = SQ_DN_CLK;
      end
      SQ_DN_CLK: begin
        if (step_done) nxt = SQ_DN_IO;
      end
      SQ_DN_IO: begin
        if (step_done) nxt = SQ_WAIT_REL;
      end
      SQ_WAIT_REL: begin
        if (cmd_vcc_n) nxt = SQ_IDLE;
      end
      default: nxt = SQ_HOLD;
    endcase
  end

  assign hold_run    = (state_q == SQ_HOLD);
  assign step_run    = is_timed(state_q);
  assign tmr_restart = (nxt != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_HOLD;
      vcc_q   <= 1'b0;
      clk_q   <= 1'b0;
      io_q    <= 1'b0;
      rst_q   <= 1'b0;
      flt_q   <= 1'b0;
    end else begin
      state_q <= nxt;
      if ((state_q == SQ_IDLE) && (nxt == SQ_UP_VCC))         vcc_q <= 1'b1;
      else if ((state_q == SQ_DN_IO) && (nxt == SQ_WAIT_REL)) vcc_q <= 1'b0;
      if ((state_q == SQ_UP_VCC) && (nxt == SQ_UP_CLK))       clk_q <= 1'b1;
      else if ((state_q == SQ_DN_RST) && (nxt == SQ_DN_CLK))  clk_q <= 1'b0;
      if ((state_q == SQ_UP_CLK) && (nxt == SQ_UP_IO))        io_q <= 1'b1;
      else if ((state_q == SQ_DN_CLK) && (nxt == SQ_DN_IO))   io_q <= 1'b0;
      rst_q <= ((state_q == SQ_LIVE) && (nxt == SQ_LIVE)) ? rst_in : 1'b0;
      if (flt_now)             flt_q <= 1'b1;
      else if (nxt == SQ_IDLE) flt_q <= 1'b0;
    end
  end

  assign vcc_en   = vcc_q;
  assign clk_en   = clk_q;
  assign io_rx_en = io_q;
  assign card_rst = rst_q;
  assign irq_n    = is_outside(state_q) ? card_present : ~flt_q;

  // R4
  clk_needs_vcc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_q |-> vcc_q);

  // R4
  io_needs_vcc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_q |-> vcc_q);

  // R3
  start_needs_card_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vcc_q) |-> $past(card_present));

  // R1
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_HOLD) |-> !vcc_q);

  // R9
  pdown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_PDOWN) |-> !(vcc_q || clk_q || io_q || rst_q));

  // R7
  supply_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vcc_q) |-> (!clk_q && !io_q && !rst_q));

  // R6
  fault_teardown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_now |=> ((state_q == SQ_DN_RST) && !rst_q && !irq_n));

  // R9
  pd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sess && pwr_dn_req) |=> (state_q != SQ_PDOWN));

endmodule

// File: rtl/card_session_seq.sv
module card_session_seq #(
  parameter int unsigned HOLD_CYC = 40000,
  parameter int unsigned STEP_CYC = 64,
  parameter int unsigned N_SUP    = 2,
  parameter int unsigned N_OCP    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vcc_n,
  input  logic             rst_in,
  input  logic             pwr_dn_req,
  input  logic             card_present,
  input  logic             vcc_ok,
  input  logic [N_SUP-1:0] sup_flt,
  input  logic [N_OCP-1:0] ocp_flt,
  output logic             vcc_en,
  output logic             clk_en,
  output logic             io_rx_en,
  output logic             card_rst,
  output logic             irq_n
);
  logic flt_any, hold_done, step_done, hold_run, step_run, tmr_restart;

  css_fault_merge #(.N_SUP(N_SUP), .N_OCP(N_OCP)) u_flt (
    .card_present (card_present),
    .sup_flt      (sup_flt),
    .ocp_flt      (ocp_flt),
    .flt_any      (flt_any)
  );

  css_cycle_timer #(.LIMIT(HOLD_CYC)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (hold_run),
    .restart (tmr_restart),
    .done    (hold_done)
  );

  css_cycle_timer #(.LIMIT(STEP_CYC)) u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (step_run),
    .restart (tmr_restart),
    .done    (step_done)
  );

  css_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_vcc_n    (cmd_vcc_n),
    .rst_in       (rst_in),
    .pwr_dn_req   (pwr_dn_req),
    .card_present (card_present),
    .vcc_ok       (vcc_ok),
    .flt_any      (flt_any),
    .hold_done    (hold_done),
    .step_done    (step_done),
    .hold_run     (hold_run),
    .step_run     (step_run),
    .tmr_restart  (tmr_restart),
    .vcc_en       (vcc_en),
    .clk_en       (clk_en),
    .io_rx_en     (io_rx_en),
    .card_rst     (card_rst),
    .irq_n        (irq_n)
  );

endmodule

// File: tb/card_session_seq_tb.sv
`timescale 1ns/1ps
module card_session_seq_tb;
  localparam int H  = 20;
  localparam int S  = 3;
  localparam int NS = 2;
  localparam int NO = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_vcc_n = 1'b1, rst_in = 1'b1, pwr_dn_req = 1'b0, card_present = 1'b1, vcc_ok = 1'b1;
  logic [NS-1:0] sup_flt = '0;
  logic [NO-1:0] ocp_flt = '0;
  logic vcc_en, clk_en, io_rx_en, card_rst, irq_n;

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;
  int vcc_r = 0, vcc_f = 0, clk_r = 0, clk_f = 0, io_r = 0, io_f = 0, rst_r = 0, rst_f = 0, irq_f = 0;
  logic p_vcc = 0, p_clk = 0, p_io = 0, p_rst = 0, p_irq = 1;

  always #2 clk = ~clk;

  card_session_seq #(.HOLD_CYC(H), .STEP_CYC(S), .N_SUP(NS), .N_OCP(NO)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_vcc_n(cmd_vcc_n), .rst_in(rst_in), .pwr_dn_req(pwr_dn_req),
    .card_present(card_present), .vcc_ok(vcc_ok), .sup_flt(sup_flt), .ocp_flt(ocp_flt),
    .vcc_en(vcc_en), .clk_en(clk_en), .io_rx_en(io_rx_en), .card_rst(card_rst), .irq_n(irq_n)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (vcc_en && !p_vcc) vcc_r = cyc;
    if (!vcc_en && p_vcc) vcc_f = cyc;
    if (clk_en && !p_clk) clk_r = cyc;
    if (!clk_en && p_clk) clk_f = cyc;
    if (io_rx_en && !p_io) io_r = cyc;
    if (!io_rx_en && p_io) io_f = cyc;
    if (card_rst && !p_rst) rst_r = cyc;
    if (!card_rst && p_rst) rst_f = cyc;
    if (!irq_n && p_irq) irq_f = cyc;
    p_vcc = vcc_en; p_clk = clk_en; p_io = io_rx_en; p_rst = card_rst; p_irq = irq_n;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic end_session();
    @(negedge clk);
    cmd_vcc_n = 1'b1; pwr_dn_req = 1'b0; card_present = 1'b1; vcc_ok = 1'b1;
    sup_flt = '0; ocp_flt = '0; rst_in = 1'b1;
    repeat (3*S + 4) @(negedge clk);
  endtask

  task automatic sweep_one(input int kind, input int off);
    int base, s, t;
    @(negedge clk);
    base = cyc; cmd_vcc_n = 1'b0; rst_in = 1'b1;
    s = base + 1;
    t = (kind == 4) ? s + ((off > S) ? off : S) : s + off;
    repeat (off) @(negedge clk);
    case (kind)
      0: cmd_vcc_n = 1'b1;
      1: card_present = 1'b0;
      2: sup_flt[off % NS] = 1'b1;
      3: ocp_flt[off % NO] = 1'b1;
      default: vcc_ok = 1'b0;
    endcase
    repeat (3*S + 4) @(negedge clk);
    chk("R4 supply rise", vcc_r, s);
    if (t > s + S) begin
      chk("R4 clock rise", clk_r, s + S);
      chk("R7 clock fall", clk_f, t + S);
    end else chk((kind == 4) ? "R5 clock held off" : "R7 clock never up", int'(clk_r <= base), 1);
    if (t > s + 2*S) begin
      chk("R4 io rise", io_r, s + 2*S);
      chk("R7 io fall", io_f, t + 2*S);
    end else chk("R4 io never up", int'(io_r <= base), 1);
    if (t > s + 3*S + 1) begin
      chk("R4 card reset rise", rst_r, s + 3*S + 1);
      chk("R7 card reset fall", rst_f, t);
    end else chk("R4 card reset never up", int'(rst_r <= base), 1);
    chk("R7 supply fall", vcc_f, t + 3*S);
    if (kind == 0) chk("R8 irq stays high", int'(irq_f <= base), 1);
    else chk((kind == 4) ? "R5 irq fall" : "R6 irq fall", irq_f, t);
    end_session();
    chk("R10 irq cleared", int'(irq_n), 1);
    chk("R10 supply off", int'(vcc_en), 0);
  endtask

  initial begin
    int base;
    card_present = 1'b1; cmd_vcc_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset vcc", int'(vcc_en), 0);
    chk("R10 reset clk", int'(clk_en), 0);
    chk("R10 reset io", int'(io_rx_en), 0);
    chk("R10 reset card_rst", int'(card_rst), 0);
    chk("R10 reset irq", int'(irq_n), 1);
    base = cyc; rst_n = 1'b1;
    repeat (H) @(negedge clk);
    chk("R1 no supply during hold", int'(vcc_en), 0);
    repeat (3) @(negedge clk);
    chk("R1 hold-off length", vcc_r, base + H + 1);
    end_session();

    // R3: absent card blocks activation
    @(negedge clk); card_present = 1'b0; cmd_vcc_n = 1'b0;
    repeat (8) @(negedge clk);
    chk("R3 no supply without card", int'(vcc_en), 0);
    chk("R10 irq shows absence", int'(irq_n), 0);
    base = cyc; card_present = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 start on insertion", vcc_r, base + 1);
    end_session();

    // R9 / R2: power-down and exit
    @(negedge clk); pwr_dn_req = 1'b1;
    @(negedge clk); base = cyc; cmd_vcc_n = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 no supply in power-down", int'(vcc_en), 0);
    chk("R9 no rise in power-down", int'(vcc_r <= base), 1);
    base = cyc; pwr_dn_req = 1'b0;
    repeat (H + 4) @(negedge clk);
    chk("R2 hold-off after power-down", vcc_r, base + H + 2);
    end_session();

    // R9: power-down ignored in session
    @(negedge clk); cmd_vcc_n = 1'b0;
    repeat (3*S + 3) @(negedge clk);
    pwr_dn_req = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 supply kept in session", int'(vcc_en), 1);
    chk("R9 io kept in session", int'(io_rx_en), 1);
    end_session();
    chk("R8 released to off", int'(vcc_en), 0);

    // R12: power-down and request together
    @(negedge clk); base = cyc; pwr_dn_req = 1'b1; cmd_vcc_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 session wins", vcc_r, base + 1);
    end_session();

    // R4: card reset follows reset-in
    @(negedge clk); cmd_vcc_n = 1'b0;
    repeat (3*S + 3) @(negedge clk);
    chk("R4 card reset high", int'(card_rst), 1);
    rst_in = 1'b0;
    @(negedge clk);
    chk("R4 card reset follows low", int'(card_rst), 0);
    rst_in = 1'b1;
    @(negedge clk);
    chk("R4 card reset follows high", int'(card_rst), 1);
    end_session();

    // R11: release and extraction on the same edge
    @(negedge clk); cmd_vcc_n = 1'b0;
    repeat (3*S + 3) @(negedge clk);
    base = cyc; cmd_vcc_n = 1'b1; card_present = 1'b0;
    @(negedge clk);
    chk("R11 fault wins irq", int'(irq_n), 0);
    repeat (3*S + 2) @(negedge clk);
    chk("R11 supply fall timing", vcc_f, base + 1 + 3*S);
    card_present = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 irq back after idle", int'(irq_n), 1);

    for (int k = 0; k < 5; k++)
      for (int o = 1; o <= 3*S + 2; o++)
        sweep_one(k, o);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule